// File: doc/BRIEF.md
# Trigger-Windowed Multi-Link Readout Aggregator

The aggregator sits between a set of per-link event FIFOs and one deeper summary FIFO that feeds a network transmit path. An external trigger starts an event. The block waits a programmable delay and then a programmable acquisition window. When the window has closed, it opens a readout interval. In that interval it first writes one event marker word to the summary FIFO. It then empties the link FIFOs one after another in ascending link order. It stays on each link until that link reports empty.

A link FIFO is read in the same cycle that its word is written to the summary FIFO. A full summary FIFO therefore stalls the drain without dropping or repeating any word. A trigger that arrives while an event is still being handled does not start a new event; it only increments a missed-trigger counter. A full flag from any link FIFO sets a sticky overflow bit for that link. The link FIFOs are first-word-fall-through: the head word is valid whenever the FIFO is not empty, and a read enable pops it at the clock edge.

Top module: `trig_link_aggregator`

## Requirements
- R1: After reset, no link read enable and no summary write are asserted, busy_o is 0, missed_o is 0 and ovf_o is 0.
- R2: A rising edge of trig_i that is sampled while busy_o is 0 starts an event, and busy_o is 1 in the following cycle. Holding trig_i high does not start another event.
- R3: With the summary FIFO not full, the marker write happens in the clock cycle that starts D+W+2 edges after the edge that sampled the trigger. Here D is delay_cyc_i and W is window_cyc_i.
- R4: The marker word has bits [63:48] = 16'hE7A5, bits [47:16] = 0, and bits [15:0] = the number of events accepted before this one. The first event after reset therefore carries 0.
- R5: After the marker, every link word appears unchanged on sum_data_o. Links come in ascending index order 0 to N_LINKS-1, and each link's words come in that FIFO's own order.
- R6: At most one link read enable is high in any cycle. It is never high for an empty link, and every link read comes with a summary write in the same cycle.
- R7: While sum_full_i is 1, sum_wr_o is 0 and no link is read. Once space frees up, the event completes with no word lost or duplicated.
- R8: A rising edge of trig_i while busy_o is 1 changes neither the current event nor the output stream. It increments missed_o by one, and missed_o saturates at 16'hFFFF.
- R9: link_full_i[k] set in a cycle makes ovf_o[k] 1 from the next cycle onward, and the bit stays 1 until reset.
- R10: Without back-pressure, busy_o stays high for D+W+3 + Σ(count_k+1) cycles, where count_k is the number of words in link k. Each empty link costs one cycle. After that, the next trigger is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | External trigger, rising-edge sensitive |
| delay_cyc_i | input | CNT_W | Trigger delay in cycles |
| window_cyc_i | input | CNT_W | Acquisition window in cycles |
| link_data_i | input | N_LINKS*64 | Head word of each link FIFO, link k at bits [64k+63:64k] |
| link_empty_i | input | N_LINKS | Link FIFO empty flags |
| link_full_i | input | N_LINKS | Link FIFO full flags |
| link_rd_o | output | N_LINKS | Link FIFO read enables (pop at clock edge) |
| sum_full_i | input | 1 | Summary FIFO full |
| sum_wr_o | output | 1 | Summary FIFO write enable |
| sum_data_o | output | 64 | Summary FIFO write data |
| busy_o | output | 1 | Event in progress |
| missed_o | output | 16 | Saturating missed-trigger count |
| ovf_o | output | N_LINKS | Sticky per-link overflow flags |

## Verification
busy_o is due one cycle after the sampling edge, and the marker is due D+W+2 edges after it. Link reads and summary writes are combinational and fall in the same cycle. The overflow and missed-trigger flags are due one cycle after their cause. The bench records the clock-edge index at which the trigger is sampled and the index at which the marker is captured. It compares their difference against D+W+3, since the capture happens one edge after the write cycle begins. It counts busy cycles at falling edges against the R10 formula. Stream contents are captured at rising edges and compared after each event against a model built from the loaded word counts. Every output is sampled at the falling edge.

// File: rtl/tla_pkg.sv
package tla_pkg;
  localparam int WORD_W = 64;
  localparam int EVT_W  = 16;
  localparam int MISS_W = 16;
  localparam logic [15:0] MARK_TAG = 16'hE7A5;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_MARK, ST_DRAIN} agg_state_e;
  typedef enum logic [1:0] {PH_IDLE, PH_DELAY, PH_WIN} win_phase_e;

  function automatic logic [WORD_W-1:0] marker_word(input logic [EVT_W-1:0] evt);
    return {MARK_TAG, 32'h0, evt};
  endfunction
endpackage

// File: rtl/tla_window_timer.sv
module tla_window_timer
  import tla_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] delay_cyc_i,
  input  logic [CNT_W-1:0] window_cyc_i,
  output logic             done_o
);
  win_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_DELAY;
          cnt_q   <= '0;
        end
        PH_DELAY: if (cnt_q == delay_cyc_i) begin
          phase_q <= PH_WIN;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        PH_WIN: if (cnt_q == window_cyc_i) phase_q <= PH_IDLE;
                else cnt_q <= cnt_q + 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // last cycle of the acquisition window
  assign done_o = (phase_q == PH_WIN) && (cnt_q == window_cyc_i);
endmodule

// File: rtl/tla_link_select.sv
module tla_link_select
  import tla_pkg::*;
#(
  parameter int N_LINKS = 4,
  parameter int IDX_W   = 2
) (
  input  logic [IDX_W-1:0]          idx_i,
  input  logic                      pop_i,
  input  logic [N_LINKS*WORD_W-1:0] link_data_i,
  input  logic [N_LINKS-1:0]        link_empty_i,
  output logic [WORD_W-1:0]         sel_data_o,
  output logic                      sel_empty_o,
  output logic [N_LINKS-1:0]        link_rd_o
);
  logic [WORD_W-1:0]  pick [N_LINKS];
  logic [N_LINKS-1:0] hit;

  for (genvar g = 0; g < N_LINKS; g++) begin : g_lane
    assign hit[g]       = (idx_i == IDX_W'(g));
    assign pick[g]      = hit[g] ? link_data_i[g*WORD_W +: WORD_W] : '0;
    assign link_rd_o[g] = pop_i && hit[g];
  end

  always_comb begin
    sel_data_o = '0;
    for (int k = 0; k < N_LINKS; k++) sel_data_o = sel_data_o | pick[k];
  end

  assign sel_empty_o = |(hit & link_empty_i);
endmodule

// File: rtl/tla_status.sv
module tla_status
  import tla_pkg::*;
#(
  parameter int N_LINKS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINKS-1:0] link_full_i,
  input  logic               miss_i,
  output logic [N_LINKS-1:0] ovf_o,
  output logic [MISS_W-1:0]  missed_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o    <= '0;
      missed_o <= '0;
    end else begin
      ovf_o <= ovf_o | link_full_i;
      if (miss_i && (missed_o != '1)) missed_o <= missed_o + 1'b1;
    end
  end
endmodule

// File: rtl/trig_link_aggregator.sv
module trig_link_aggregator
  import tla_pkg::*;
#(
  parameter int N_LINKS = 4,
  parameter int CNT_W   = 12
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      trig_i,
  input  logic [CNT_W-1:0]          delay_cyc_i,
  input  logic [CNT_W-1:0]          window_cyc_i,
  input  logic [N_LINKS*WORD_W-1:0] link_data_i,
  input  logic [N_LINKS-1:0]        link_empty_i,
  input  logic [N_LINKS-1:0]        link_full_i,
  output logic [N_LINKS-1:0]        link_rd_o,
  input  logic                      sum_full_i,
  output logic                      sum_wr_o,
  output logic [WORD_W-1:0]         sum_data_o,
  output logic                      busy_o,
  output logic [MISS_W-1:0]         missed_o,
  output logic [N_LINKS-1:0]        ovf_o
);
  localparam int IDX_W = (N_LINKS > 1) ? $clog2(N_LINKS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_LINKS - 1);

  agg_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [EVT_W-1:0] evt_q;
  logic             trig_q;
  logic             trig_rise, accept, miss, win_done;
  logic             pop, mark_wr, sel_empty;
  logic [WORD_W-1:0] sel_data;

  assign trig_rise = trig_i && !trig_q;
  assign accept    = trig_rise && (state_q == ST_IDLE);
  assign miss      = trig_rise && (state_q != ST_IDLE);
  assign mark_wr   = (state_q == ST_MARK) && !sum_full_i;
  assign pop       = (state_q == ST_DRAIN) && !sel_empty && !sum_full_i;

  tla_window_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni,
    .start_i      (accept),
    .delay_cyc_i,
    .window_cyc_i,
    .done_o       (win_done)
  );

  tla_link_select #(.N_LINKS(N_LINKS), .IDX_W(IDX_W)) u_sel (
    .idx_i        (idx_q),
    .pop_i        (pop),
    .link_data_i,
    .link_empty_i,
    .sel_data_o   (sel_data),
    .sel_empty_o  (sel_empty),
    .link_rd_o
  );

  tla_status #(.N_LINKS(N_LINKS)) u_status (
    .clk_i, .rst_ni,
    .link_full_i,
    .miss_i   (miss),
    .ovf_o,
    .missed_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      evt_q   <= '0;
      trig_q  <= 1'b0;
    end else begin
      trig_q <= trig_i;
      case (state_q)
        ST_IDLE:  if (accept) state_q <= ST_WAIT;
        ST_WAIT:  if (win_done) state_q <= ST_MARK;
        ST_MARK:  if (!sum_full_i) begin
          state_q <= ST_DRAIN;
          idx_q   <= '0;
          evt_q   <= evt_q + 1'b1;
        end
        ST_DRAIN: if (sel_empty) begin
          if (idx_q == LAST_IDX) state_q <= ST_IDLE;
          else idx_q <= idx_q + 1'b1;
        end
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign sum_wr_o   = mark_wr || pop;
  assign sum_data_o = mark_wr ? marker_word(evt_q) : sel_data;
  assign busy_o     = (state_q != ST_IDLE);
endmodule

// File: rtl/tla_checker.sv
module tla_checker
  import tla_pkg::*;
#(
  parameter int N_LINKS = 4,
  parameter int CNT_W   = 12
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      trig_i,
  input logic [N_LINKS-1:0]        link_empty_i,
  input logic [N_LINKS-1:0]        link_full_i,
  input logic [N_LINKS-1:0]        link_rd_o,
  input logic                      sum_full_i,
  input logic                      sum_wr_o,
  input logic                      busy_o,
  input logic [MISS_W-1:0]         missed_o,
  input logic [N_LINKS-1:0]        ovf_o
);
  localparam int IDX_W = (N_LINKS > 1) ? $clog2(N_LINKS) : 1;

  logic             trg_q;
  logic [IDX_W-1:0] last_q, rd_idx;

  always_comb begin
    rd_idx = '0;
    for (int k = 0; k < N_LINKS; k++) if (link_rd_o[k]) rd_idx = IDX_W'(k);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trg_q  <= 1'b0;
      last_q <= '0;
    end else begin
      trg_q <= trig_i;
      if (!busy_o) last_q <= '0;
      else if (|link_rd_o) last_q <= rd_idx;
    end
  end

  // R2
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && !trg_q && !busy_o) |=> busy_o);
  // R5
  link_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|link_rd_o) |-> (rd_idx >= last_q));
  // R6
  one_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(link_rd_o) && ((link_rd_o & link_empty_i) == '0));
  // R6
  read_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|link_rd_o) |-> sum_wr_o);
  // R7
  no_write_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_full_i |-> (!sum_wr_o && (link_rd_o == '0)));
  // R8
  missed_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && !trg_q && busy_o && (missed_o != '1)) |=> (missed_o == $past(missed_o) + 16'd1));
  // R9
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|link_full_i) |=> ((ovf_o & $past(link_full_i)) == $past(link_full_i)));
  // R9
  ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ovf_o) |=> ((ovf_o & $past(ovf_o)) == $past(ovf_o)));
endmodule

bind trig_link_aggregator tla_checker #(.N_LINKS(N_LINKS), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_i), .link_empty_i(link_empty_i),
  .link_full_i(link_full_i), .link_rd_o(link_rd_o), .sum_full_i(sum_full_i),
  .sum_wr_o(sum_wr_o), .busy_o(busy_o), .missed_o(missed_o), .ovf_o(ovf_o)
);

// File: tb/tb_trig_link_aggregator.sv
module tb_trig_link_aggregator;
  localparam int N = 4;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig = 1'b0;
  logic [CW-1:0] dly_cfg = '0, win_cfg = '0;
  logic [N*64-1:0] link_data;
  logic [N-1:0]  link_empty, link_full = '0, link_rd, ovf;
  logic          sum_full, sum_wr, busy;
  logic [63:0]   sum_data;
  logic [15:0]   missed;
  logic          bp_en = 1'b0, bp_hold = 1'b0;
  logic [15:0]   lfsr = 16'hACE1;

  logic [63:0] fmem [N][64];
  int wp [N];
  int rp [N];
  logic [63:0] rx [1024];
  int rx_n = 0, ev_base = 0, first_cyc = 0, cyc = 0, viol = 0;
  int n_chk = 0, n_fail = 0, exp_evt = 0;

  always #10 clk = ~clk;

  trig_link_aggregator #(.N_LINKS(N), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .delay_cyc_i(dly_cfg),
    .window_cyc_i(win_cfg), .link_data_i(link_data), .link_empty_i(link_empty),
    .link_full_i(link_full), .link_rd_o(link_rd), .sum_full_i(sum_full),
    .sum_wr_o(sum_wr), .sum_data_o(sum_data), .busy_o(busy), .missed_o(missed),
    .ovf_o(ovf)
  );

  for (genvar g = 0; g < N; g++) begin : g_fifo
    assign link_empty[g]        = (wp[g] == rp[g]);
    assign link_data[g*64 +: 64] = fmem[g][rp[g] % 64];
  end
  assign sum_full = bp_hold | (bp_en & lfsr[0]);

  initial for (int k = 0; k < N; k++) begin wp[k] = 0; rp[k] = 0; end

  always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    for (int k = 0; k < N; k++) if (link_rd[k]) rp[k] <= rp[k] + 1;
    if (sum_wr) begin
      if (rx_n == ev_base) first_cyc <= cyc;
      rx[rx_n % 1024] <= sum_data;
      rx_n <= rx_n + 1;
    end
    // R6 monitor
    if (rst_n) begin
      if ((link_rd != '0) && !sum_wr) viol <= viol + 1;
      if ($countones(link_rd) > 1) viol <= viol + 1;
      if ((link_rd & link_empty) != '0) viol <= viol + 1;
    end
  end

  function automatic logic [63:0] wword(input int ev, input int k, input int j);
    logic [31:0] h;
    h = {8'(ev), 8'(k), 16'(j)};
    return {h, ~h};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  // bp: random summary back-pressure; extra_at: second trigger while busy;
  // hold_lvl: keep trig high; stall: cycles of forced summary full at start
  task automatic run_event(input int d, input int w, input int c0, input int c1,
                           input int c2, input int c3, input bit bp,
                           input int extra_at, input bit hold_lvl, input int stall);
    int cnt [N];
    int ev, base, busy_n, miss0, tc, pos, k, sumc;
    bit ok;
    cnt[0] = c0; cnt[1] = c1; cnt[2] = c2; cnt[3] = c3;
    ev = exp_evt;
    @(negedge clk);
    for (int l = 0; l < N; l++) begin
      for (int j = 0; j < cnt[l]; j++) fmem[l][(wp[l] + j) % 64] = wword(ev, l, j);
      wp[l] = wp[l] + cnt[l];
    end
    dly_cfg = CW'(d); win_cfg = CW'(w);
    bp_en = bp; bp_hold = (stall > 0);
    ev_base = rx_n; base = rx_n; miss0 = int'(missed);
    trig = 1'b1; tc = cyc;
    @(negedge clk);
    if (!hold_lvl) trig = 1'b0;
    chk(busy == 1'b1, "R2 busy after accepted trigger", 64'(busy), 64'd1);
    busy_n = 1;
    if (stall > 0) begin
      repeat (stall) begin @(negedge clk); busy_n++; end
      chk(rx_n == base, "R7 no write while summary full", 64'(rx_n - base), 64'd0);
      bp_hold = 1'b0;
    end
    k = 1;
    while (busy && k < 4000) begin
      if (extra_at > 0 && k == extra_at) trig = 1'b1;
      else if (extra_at > 0 && k == extra_at + 1) trig = 1'b0;
      @(negedge clk);
      if (busy) busy_n++;
      k++;
    end
    bp_en = 1'b0;
    if (hold_lvl) begin
      repeat (4) @(negedge clk);
      chk(busy == 1'b0, "R2 held level does not restart", 64'(busy), 64'd0);
      trig = 1'b0;
    end
    if (!bp && stall == 0) begin
      chk(first_cyc - tc == d + w + 3, "R3 marker timing", 64'(first_cyc - tc), 64'(d + w + 3));
      sumc = d + w + 3;
      for (int l = 0; l < N; l++) sumc += cnt[l] + 1;
      chk(busy_n == sumc, "R10 busy duration", 64'(busy_n), 64'(sumc));
    end
    chk(rx[base % 1024] == {16'hE7A5, 32'h0, 16'(ev)}, "R4 marker word",
        rx[base % 1024], {16'hE7A5, 32'h0, 16'(ev)});
    ok = 1'b1; pos = base + 1; sumc = 1;
    for (int l = 0; l < N; l++) begin
      for (int j = 0; j < cnt[l]; j++) begin
        if (ok && rx[pos % 1024] != wword(ev, l, j)) begin
          ok = 1'b0;
          chk(1'b0, "R5 stream word", rx[pos % 1024], wword(ev, l, j));
        end
        pos++;
      end
      sumc += cnt[l];
    end
    chk(ok && (rx_n - base == sumc), "R5 stream length", 64'(rx_n - base), 64'(sumc));
    chk(int'(missed) == miss0 + ((extra_at > 0) ? 1 : 0), "R8 missed count",
        64'(missed), 64'(miss0 + ((extra_at > 0) ? 1 : 0)));
    exp_evt++;
  endtask

  // {bp[3:0], delay[5:0], window[5:0], c3, c2, c1, c0}
  localparam logic [39:0] VEC [6] = '{
    {4'd0, 6'd3, 6'd5, 6'd1,  6'd4,  6'd2,  6'd3},
    {4'd0, 6'd0, 6'd0, 6'd1,  6'd1,  6'd1,  6'd1},
    {4'd1, 6'd2, 6'd4, 6'd3,  6'd7,  6'd0,  6'd10},
    {4'd0, 6'd7, 6'd9, 6'd0,  6'd0,  6'd5,  6'd0},
    {4'd1, 6'd1, 6'd1, 6'd12, 6'd25, 6'd15, 6'd20},
    {4'd0, 6'd4, 6'd2, 6'd6,  6'd0,  6'd0,  6'd0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(link_rd == '0 && !sum_wr && !busy, "R1 reset outputs idle", {link_rd, sum_wr, busy}, 64'd0);
    chk(missed == '0 && ovf == '0, "R1 reset status", {missed, ovf}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      logic [39:0] v;
      v = VEC[i];
      run_event(int'(v[35:30]), int'(v[29:24]), int'(v[5:0]), int'(v[11:6]),
                int'(v[17:12]), int'(v[23:18]), v[36], 0, 1'b0, 0);
    end

    run_event(5, 5, 2, 2, 2, 2, 1'b0, 3, 1'b0, 0);  // R8 trigger while busy
    run_event(1, 1, 1, 0, 2, 0, 1'b0, 0, 1'b1, 0);  // R2 level held
    run_event(2, 3, 0, 0, 0, 0, 1'b0, 0, 1'b0, 0);  // R10 all links empty
    run_event(1, 2, 3, 3, 3, 3, 1'b0, 0, 1'b0, 12); // R7 summary full stall

    // R9 overflow sticky
    @(negedge clk); link_full = 4'b0100;
    @(negedge clk); link_full = '0;
    chk(ovf == 4'b0100, "R9 overflow set", 64'(ovf), 64'(4'b0100));
    repeat (5) @(negedge clk);
    chk(ovf == 4'b0100, "R9 overflow held", 64'(ovf), 64'(4'b0100));

    chk(viol == 0, "R6 read/write pairing", 64'(viol), 64'd0);
    summary();
  end
endmodule